// File: doc/BRIEF.md
# Bus Timeout Watchdog with Fault Capture

This block sits next to a pipelined bus master and detects accesses that never complete. It observes the master's cycle, strobe and acknowledge lines and runs a down-counter. The counter is reloaded by any bus activity and counts only while a cycle is open. If it runs out during an open cycle, the block raises a one-clock timeout. That timeout is ORed with the slave's error line to form the error the master sees, and it also serves as the single interrupt output.

When a timeout fires, or when the slave reports an error, the block stores the master's current address in a fault register. Software reads that address through a single-register slave port, which acknowledges one clock after its strobe. The timeout length is a build-time parameter and cannot be changed at run time. By default the block waits 0x2000 idle clocks and uses a 14-bit counter.

Top module: `bus_timeout_guard`

## Requirements
- R1: During and after reset, the timeout output is low, the fault register reads zero, and the merged error equals the slave error.
- R2: In every clock where the cycle line is high and strobe or acknowledge is also high, the counter is reloaded to TIMEOUT. A slave that answers after TIMEOUT-1 or fewer idle clocks never trips the timeout.
- R3: While the cycle line is low, the counter neither counts nor reloads. Idle clocks on either side of a cycle-low gap add up toward the timeout.
- R4: After the reloading clock, the timeout pulse appears in the cycle that follows the TIMEOUT-th idle clock edge with the cycle line high.
- R5: The timeout is a pulse one clock wide. The counter then holds at zero until the next reload, so one stuck access gives exactly one pulse.
- R6: The cycle after a timeout pulse, the fault register holds the master address that was present during the pulse.
- R7: A slave error in any clock stores that clock's master address in the fault register on the next clock.
- R8: The merged error output is the OR of the slave error and the timeout pulse, with no added delay.
- R9: The register port raises its acknowledge exactly one clock after each strobe. A read returns the fault address zero-extended into bits 31:0, with the address in the low bits.
- R10: A strobe with the write flag set is acknowledged, but it leaves the fault register unchanged.
- R11: Asserting reset while a cycle is stalled reloads the counter. After release, the full TIMEOUT idle clocks are needed again before a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_cyc | input | 1 | Master cycle line, high while a bus cycle is open |
| m_stb | input | 1 | Master strobe, a request issued this clock |
| m_ack | input | 1 | Slave acknowledge observed on the bus |
| m_addr | input | ADDR_W | Master address |
| s_err | input | 1 | Error reported by the slave |
| m_err | output | 1 | Merged error returned to the master |
| timeout_o | output | 1 | One-clock timeout pulse, used as the interrupt |
| cfg_stb | input | 1 | Register port strobe |
| cfg_we | input | 1 | Register port write flag (write is ignored) |
| cfg_ack | output | 1 | Register port acknowledge, one clock after the strobe |
| cfg_rdata | output | 32 | Fault address, zero-extended |

## Verification
The bench builds the block with TIMEOUT of 40, a 6-bit counter and a 20-bit address. With these values, stalls shorter than, equal to and far beyond the limit all fit in a few hundred clocks. Many randomly sized stalls can also run within the cycle budget. The 20-bit address leaves twelve high bits of the read word that must come back as zero. The short limit also lets a directed case split the idle count across a cycle-low gap and check the exact clock of the pulse.

// File: rtl/bto_pkg.sv
package bto_pkg;
  localparam int REG_W = 32;

  typedef struct packed {
    logic cyc;
    logic stb;
    logic ack;
  } bus_obs_t;

  function automatic logic bus_active(bus_obs_t o);
    return o.cyc && (o.stb || o.ack);
  endfunction
endpackage

// File: rtl/bto_timer.sv
module bto_timer
  import bto_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int TIMEOUT = 'h2000
) (
  input  logic     clk,
  input  logic     rst,
  input  bus_obs_t obs_i,
  output logic     fire_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(TIMEOUT);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             fire_q;
  logic             reload;

  assign reload = bus_active(obs_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= LOAD;
      fire_q <= 1'b0;
    end else if (reload) begin
      cnt_q  <= LOAD;
      fire_q <= 1'b0;
    end else if (obs_i.cyc && (cnt_q != '0)) begin
      cnt_q  <= cnt_q - ONE;
      fire_q <= (cnt_q == ONE);
    end else begin
      fire_q <= 1'b0;
    end
  end

  assign fire_o = fire_q;

  // R2
  reload_on_activity_chk: assert property (@(posedge clk) disable iff (rst)
    bus_active(obs_i) |=> (cnt_q == LOAD));

  // R3
  idle_bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !obs_i.cyc |=> $stable(cnt_q));

  // R4
  fire_after_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    fire_q |-> ($past(obs_i.cyc) && ($past(cnt_q) == ONE)));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fire_q |=> !fire_q);

  // R5
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((cnt_q == '0) && !bus_active(obs_i)) |=> ((cnt_q == '0) && !fire_q));
endmodule

// File: rtl/bto_fault_latch.sv
module bto_fault_latch #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tmo_i,
  input  logic              serr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] fault_o
);
  logic [ADDR_W-1:0] fault_q;

  always_ff @(posedge clk) begin
    if (rst)
      fault_q <= '0;
    else if (tmo_i || serr_i)
      fault_q <= addr_i;
  end

  assign fault_o = fault_q;

  // R6
  tmo_capture_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_i |=> (fault_q == $past(addr_i)));

  // R7
  serr_capture_chk: assert property (@(posedge clk) disable iff (rst)
    serr_i |=> (fault_q == $past(addr_i)));

  // R10
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tmo_i && !serr_i) |=> $stable(fault_q));
endmodule

// File: rtl/bto_reg_port.sv
module bto_reg_port
  import bto_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] fault_i,
  output logic              ack_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic [REG_W-1:0] ext;
  logic             ack_q;
  logic [REG_W-1:0] rdata_q;

  generate
    if (ADDR_W < REG_W) begin : g_pad
      assign ext = {{(REG_W-ADDR_W){1'b0}}, fault_i};
    end else begin : g_trim
      assign ext = fault_i[REG_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= stb_i;
      if (stb_i && !we_i)
        rdata_q <= ext;
    end
  end

  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;

  // R9
  ack_follows_stb_chk: assert property (@(posedge clk) disable iff (rst)
    stb_i |=> ack_q);

  // R9
  ack_needs_stb_chk: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> $past(stb_i));
endmodule

// File: rtl/bus_timeout_guard.sv
module bus_timeout_guard
  import bto_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int CNT_W   = 14,
  parameter int TIMEOUT = 'h2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m_cyc,
  input  logic              m_stb,
  input  logic              m_ack,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic              s_err,
  output logic              m_err,
  output logic              timeout_o,
  input  logic              cfg_stb,
  input  logic              cfg_we,
  output logic              cfg_ack,
  output logic [REG_W-1:0]  cfg_rdata
);
  bus_obs_t          obs;
  logic              fire;
  logic [ADDR_W-1:0] fault;

  assign obs = '{cyc: m_cyc, stb: m_stb, ack: m_ack};

  bto_timer #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst(rst), .obs_i(obs), .fire_o(fire)
  );

  bto_fault_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst(rst), .tmo_i(fire), .serr_i(s_err),
    .addr_i(m_addr), .fault_o(fault)
  );

  bto_reg_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst), .stb_i(cfg_stb), .we_i(cfg_we),
    .fault_i(fault), .ack_o(cfg_ack), .rdata_o(cfg_rdata)
  );

  assign m_err     = s_err | fire;
  assign timeout_o = fire;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!timeout_o && (cfg_rdata == '0)));
endmodule

// File: tb/bus_timeout_guard_tb_top.sv
module bus_timeout_guard_tb_top;
  localparam int AW = 20;
  localparam int CW = 6;
  localparam int TO = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          m_cyc = 0, m_stb = 0, m_ack = 0, s_err = 0;
  logic [AW-1:0] m_addr = '0;
  logic          m_err, timeout_o;
  logic          cfg_stb = 0, cfg_we = 0, cfg_ack;
  logic [31:0]   cfg_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [AW-1:0] last_fault = '0;

  always #10 clk = ~clk;

  bus_timeout_guard #(.ADDR_W(AW), .CNT_W(CW), .TIMEOUT(TO)) dut_i (
    .clk(clk), .rst(rst), .m_cyc(m_cyc), .m_stb(m_stb), .m_ack(m_ack),
    .m_addr(m_addr), .s_err(s_err), .m_err(m_err), .timeout_o(timeout_o),
    .cfg_stb(cfg_stb), .cfg_we(cfg_we), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
  );

  function automatic int exp_pulses(int idle);
    return (idle >= TO) ? 1 : 0;
  endfunction

  function automatic logic [31:0] exp_word(logic [AW-1:0] a);
    return {{(32-AW){1'b0}}, a};
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_fault(string req, logic [31:0] exp);
    @(negedge clk); cfg_stb = 1; cfg_we = 0;
    @(negedge clk);
    chk(cfg_ack == 1'b1, "R9 ack", cfg_ack, 1);
    chk(cfg_rdata == exp, req, cfg_rdata, exp);
    cfg_stb = 0;
    @(negedge clk);
    chk(cfg_ack == 1'b0, "R9 ack drop", cfg_ack, 0);
  endtask

  task automatic run_txn(logic [AW-1:0] a, int idle, bit finish, output int pulses, output int first_at);
    pulses = 0; first_at = -1;
    @(negedge clk); m_cyc = 1; m_stb = 1; m_addr = a;
    @(negedge clk); m_stb = 0;
    for (int i = 1; i <= idle; i++) begin
      @(negedge clk);
      if (timeout_o) begin
        pulses++;
        if (first_at < 0) first_at = i;
        chk(m_err == 1'b1, "R8 merged err on timeout", m_err, 1);
      end
    end
    if (finish) begin
      m_ack = 1;
      @(negedge clk);
      chk(timeout_o == 1'b0, "R2 ack edge no pulse", timeout_o, 0);
      m_ack = 0;
    end
    m_cyc = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int p, f, idle;
    logic [AW-1:0] a;
    void'($urandom(32'd2024));
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(timeout_o == 0, "R1 timeout in reset", timeout_o, 0);
    chk(m_err == 0, "R1 err in reset", m_err, 0);
    rst = 0;
    read_fault("R1 fault after reset", 32'h0);

    // R2 one below the limit
    run_txn(20'h1234A, TO-1, 1, p, f);
    chk(p == 0, "R2 no trip at TO-1", p, 0);
    read_fault("R2 fault untouched", exp_word(last_fault));

    // R4 R6 exact expiry and capture
    run_txn(20'hABCDE, TO+10, 1, p, f);
    chk(p == 1, "R5 one pulse", p, 1);
    chk(f == TO, "R4 pulse clock", f, TO);
    last_fault = 20'hABCDE;
    read_fault("R6 captured address", exp_word(last_fault));

    // R5 never-responding slave
    run_txn(20'hF0F0F, 3*TO, 0, p, f);
    chk(p == 1, "R5 stuck slave one pulse", p, 1);
    last_fault = 20'hF0F0F;
    read_fault("R6 stuck slave address", exp_word(last_fault));

    // R3 idle count spans a cycle-low gap
    run_txn(20'h00777, TO-5, 0, p, f);
    chk(p == 0, "R3 first part", p, 0);
    p = 0;
    repeat (20) begin @(negedge clk); if (timeout_o) p++; end
    m_cyc = 1;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (i < 5) chk(timeout_o == 0, "R3 early", timeout_o, 0);
      else       chk(timeout_o == 1, "R3 pulse after gap", timeout_o, 1);
    end
    chk(p == 0, "R3 gap no count", p, 0);
    m_cyc = 0;
    last_fault = 20'h00777;
    read_fault("R6 gap capture", exp_word(last_fault));

    // R11 reset during stall
    run_txn(20'h05555, TO-3, 0, p, f);
    @(negedge clk); m_cyc = 1; rst = 1;
    @(negedge clk); rst = 0; last_fault = '0;
    p = 0; f = -1;
    for (int i = 1; i <= TO; i++) begin
      @(negedge clk);
      if (timeout_o) begin p++; if (f < 0) f = i; end
    end
    chk(f == TO, "R11 full window after reset", f, TO);
    m_cyc = 0;
    last_fault = 20'h05555;
    read_fault("R11 capture after reset", exp_word(last_fault));

    // R7 R8 slave error
    @(negedge clk); m_cyc = 1; m_stb = 1; m_addr = 20'h9A9A9; s_err = 1;
    #1;
    chk(m_err == 1, "R8 err passes through", m_err, 1);
    chk(timeout_o == 0, "R8 no timeout", timeout_o, 0);
    @(negedge clk); s_err = 0; m_stb = 0; m_cyc = 0;
    #1;
    chk(m_err == 0, "R8 err clears", m_err, 0);
    last_fault = 20'h9A9A9;
    read_fault("R7 error capture", exp_word(last_fault));

    // R10 write ignored
    @(negedge clk); cfg_stb = 1; cfg_we = 1;
    @(negedge clk);
    chk(cfg_ack == 1, "R10 write acked", cfg_ack, 1);
    cfg_stb = 0; cfg_we = 0;
    read_fault("R10 write ignored", exp_word(last_fault));

    // random stalls around the limit
    for (int k = 0; k < 14; k++) begin
      if (k == 0) idle = TO - 1;
      else if (k == 1) idle = TO;
      else idle = int'($urandom_range(2*TO, 0));
      a = AW'($urandom);
      run_txn(a, idle, 1, p, f);
      chk(p == exp_pulses(idle), "R2 R4 random stall", p, exp_pulses(idle));
      if (exp_pulses(idle) == 1) begin
        chk(f == TO, "R4 random pulse clock", f, TO);
        last_fault = a;
      end
      read_fault("R6 random fault", exp_word(last_fault));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule